// File: doc/BRIEF.md
# Debug Mode Status Controller

This block keeps the status and control state of an on-chip background debug port. It holds an enable flag, an active flag, a data-phase-complete flag, a single-step flag and an unsecure flag, and it updates each one from single-cycle event strobes. The debug serial link, the firmware tables and the CPU are not part of the block. They drive the strobes: debug entry, the exit store, the decoded commands, data-phase completion, secure-mode entry and the result of the flash erase check.

The block also keeps a condition-code holding register. It captures the user program's flags on a granted debug entry and can be overwritten before they are restored. After reset the controller sets the enable flag by itself in special single-chip mode. On a secured device this waits until the erase check has reported. The block also decides, in the same cycle, whether a debug entry or a firmware command is allowed.

Top module: `dbg_stat_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the status byte becomes 0x00. Every flag is cleared.
- R2: The enable flag is status bit 7. It takes bit 7 of a status write. While it is 0, `entry_grant_o` stays 0 and the active flag cannot be set. Hardware commands (a read or write strobe with `cmd_fw_i` = 0) still set and clear the data flag.
- R3: The active flag is status bit 6. It is set one cycle after a debug entry while enabled (`entry_grant_o` = 1). Only `exit_store_i` clears it.
- R4: The data flag is status bit 4. `rd_done_i` or `wr_done_i` sets it. Any command strobe or `exit_store_i` clears it. When both happen in one cycle, the clear wins.
- R5: The step flag is status bit 3. A step command sets it when enable and active are both 1. A go or go-until command under the same condition clears it, and the clear wins.
- R6: The unsecure flag is status bit 1. `sec_enter_i` forces it to 0. `verify_done_i` with `verify_pass_i` = 1 sets it. A failed check leaves it unchanged, and the clear wins over the set.
- R7: Bit 1 of a status write reaches the unsecure flag only if `secured_i` = 0 or `ssc_mode_i` = 1. Otherwise the write is ignored. It also has the lowest priority of the three events on that flag.
- R8: Status bits 5, 2 and 0 always read 0. A status write has no effect on bits 6, 5, 4, 3, 2 and 0.
- R9: A granted entry captures `ccr_user_i` into the holding register. Otherwise `ccr_wr_i` loads `ccr_wdata_i`. A capture wins over a write in the same cycle.
- R10: In reset the holding register becomes 0xA0 if `ssc_mode_i` = 1, and 0x00 if it is 0.
- R11: In special single-chip mode, the enable flag is set one cycle after reset ends on an unsecured device. On a secured device it is set one cycle after `verify_done_i`. Outside that mode it is never set by itself. The automatic set happens at most once per reset.
- R12: `fw_grant_o` is 1 in the same cycle as a firmware command when enable and active are both 1. The firmware commands are step, go, go-until, and a read or write with `cmd_fw_i` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ssc_mode_i | input | 1 | Special single-chip mode |
| secured_i | input | 1 | Device is secured |
| stat_wr_i | input | 1 | Status byte write strobe |
| stat_wdata_i | input | 8 | Status write data |
| entry_i | input | 1 | Debug entry event |
| exit_store_i | input | 1 | Exit store back to user code |
| cmd_rd_i | input | 1 | Read command received |
| cmd_wr_i | input | 1 | Write command received |
| cmd_fw_i | input | 1 | Read/write command is firmware class |
| cmd_step_i | input | 1 | Step (trace-one) command received |
| cmd_go_i | input | 1 | Go command received |
| cmd_gountil_i | input | 1 | Go-until command received |
| rd_done_i | input | 1 | Read data phase transmitted |
| wr_done_i | input | 1 | Write data phase received |
| sec_enter_i | input | 1 | Secure mode entered |
| verify_done_i | input | 1 | Erase check finished |
| verify_pass_i | input | 1 | Erase check result |
| ccr_user_i | input | 8 | User condition code at entry |
| ccr_wr_i | input | 1 | Holding register write strobe |
| ccr_wdata_i | input | 8 | Holding register write data |
| status_o | output | 8 | Status byte |
| ccr_hold_o | output | 8 | Condition-code holding register |
| entry_grant_o | output | 1 | Entry accepted this cycle |
| fw_grant_o | output | 1 | Firmware command accepted this cycle |

## Verification
The bench targets same-cycle collisions on each flag. A data-phase completion arrives together with a new command, a step together with a go, and a passing erase check together with secure entry. A design that let the set win would leave a stale 1 in the status byte. The bench also tries status writes to the unsecure bit while secured outside special single-chip mode, and writes to reserved and hardware-owned bits. A leaky write path would show up directly as a wrong status bit.

The bench times the automatic enable in both mode and security combinations. An early set, or a set repeated after software clears the flag, would show as an unexpected bit 7. Entry is also tried while the enable flag is clear; a wrong gate would grant it and raise the active flag. Entry together with a holding-register write exposes a wrong capture priority.

// File: rtl/dbg_stat_pkg.sv
package dbg_stat_pkg;
   localparam int ST_W   = 8;
   localparam int NFLAG  = 5;
   // flag indices inside the flag vector
   localparam int F_EN   = 0;
   localparam int F_ACT  = 1;
   localparam int F_SDV  = 2;
   localparam int F_STEP = 3;
   localparam int F_UNS  = 4;

   // status byte bit position of each flag
   function automatic int flag_bit(input int idx);
      case (idx)
         F_EN:    return 7;
         F_ACT:   return 6;
         F_SDV:   return 4;
         F_STEP:  return 3;
         default: return 1;
      endcase
   endfunction

   // the enable flag gives software writes priority over its automatic set
   function automatic bit flag_wr_first(input int idx);
      return idx == F_EN;
   endfunction

   typedef enum logic {AE_PEND = 1'b0, AE_DONE = 1'b1} ae_state_t;
endpackage

// File: rtl/dbg_flag_cell.sv
module dbg_flag_cell #(
   parameter bit CLR_WINS    = 1'b1,
   parameter bit WR_OVER_SET = 1'b0,
   parameter bit RST_VAL     = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic wr_i,
   input  logic wd_i,
   output logic q_o
);
   logic q_nxt;

   always_comb begin
      q_nxt = q_o;
      if (wr_i && !WR_OVER_SET) q_nxt = wd_i;
      if (set_i) q_nxt = 1'b1;
      if (clr_i && (CLR_WINS || !set_i)) q_nxt = 1'b0;
      if (wr_i && WR_OVER_SET) q_nxt = wd_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q_o <= RST_VAL;
      else        q_o <= q_nxt;
   end

   generate
      if (CLR_WINS) begin : g_clr_chk
         // R4, R5, R6: a clear beats a simultaneous set
         a_r4_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i && !(wr_i && WR_OVER_SET)) |=> !q_o);
      end
   endgenerate
endmodule

// File: rtl/dbg_auto_en.sv
module dbg_auto_en
   import dbg_stat_pkg::*;
#(
   parameter bit ENABLE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ssc_mode_i,
   input  logic secured_i,
   input  logic verify_done_i,
   output logic en_set_o
);
   generate
      if (ENABLE) begin : g_auto
         ae_state_t state_q, state_d;
         logic      fire;

         assign fire = (state_q == AE_PEND) && ssc_mode_i
                       && (!secured_i || verify_done_i);

         always_comb begin
            state_d = state_q;
            if (state_q == AE_PEND && (fire || !ssc_mode_i)) state_d = AE_DONE;
         end

         always_ff @(posedge clk) begin
            if (!rst_n) state_q <= AE_PEND;
            else        state_q <= state_d;
         end

         assign en_set_o = fire;

         // R11: the automatic enable fires only once per reset
         a_r11_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
            en_set_o |=> !en_set_o);
         // R11: no automatic enable outside special single-chip mode
         a_r11_ssc_only: assert property (@(posedge clk) disable iff (!rst_n)
            en_set_o |-> ssc_mode_i);
      end else begin : g_none
         assign en_set_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/dbg_flag_bank.sv
module dbg_flag_bank
   import dbg_stat_pkg::*;
#(
   parameter bit CLR_WINS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ssc_mode_i,
   input  logic             secured_i,
   input  logic             stat_wr_i,
   input  logic [ST_W-1:0]  stat_wdata_i,
   input  logic             auto_en_i,
   input  logic             entry_i,
   input  logic             exit_store_i,
   input  logic             cmd_rd_i,
   input  logic             cmd_wr_i,
   input  logic             cmd_fw_i,
   input  logic             cmd_step_i,
   input  logic             cmd_go_i,
   input  logic             cmd_gountil_i,
   input  logic             rd_done_i,
   input  logic             wr_done_i,
   input  logic             sec_enter_i,
   input  logic             verify_done_i,
   input  logic             verify_pass_i,
   output logic [ST_W-1:0]  status_o,
   output logic             entry_grant_o,
   output logic             fw_grant_o
);
   logic [NFLAG-1:0] q, set_v, clr_v, wr_v, wd_v;
   logic fw_ok, any_cmd, fw_cmd, go_any, uns_wr_ok;

   assign fw_ok     = q[F_EN] & q[F_ACT];
   assign any_cmd   = cmd_rd_i | cmd_wr_i | cmd_step_i | cmd_go_i | cmd_gountil_i;
   assign go_any    = cmd_go_i | cmd_gountil_i;
   assign fw_cmd    = cmd_step_i | go_any | ((cmd_rd_i | cmd_wr_i) & cmd_fw_i);
   assign uns_wr_ok = !secured_i || ssc_mode_i;

   assign entry_grant_o = entry_i & q[F_EN];
   assign fw_grant_o    = fw_cmd & fw_ok;

   always_comb begin
      set_v = '0;
      clr_v = '0;
      wr_v  = '0;
      wd_v  = '0;
      // enable: software write, automatic set
      wr_v[F_EN]    = stat_wr_i;
      wd_v[F_EN]    = stat_wdata_i[flag_bit(F_EN)];
      set_v[F_EN]   = auto_en_i;
      // active
      set_v[F_ACT]  = entry_grant_o;
      clr_v[F_ACT]  = exit_store_i;
      // data phase complete
      set_v[F_SDV]  = rd_done_i | wr_done_i;
      clr_v[F_SDV]  = any_cmd | exit_store_i;
      // single step
      set_v[F_STEP] = cmd_step_i & fw_ok;
      clr_v[F_STEP] = go_any & fw_ok;
      // unsecure
      set_v[F_UNS]  = verify_done_i & verify_pass_i;
      clr_v[F_UNS]  = sec_enter_i;
      wr_v[F_UNS]   = stat_wr_i & uns_wr_ok;
      wd_v[F_UNS]   = stat_wdata_i[flag_bit(F_UNS)];
   end

   for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
      dbg_flag_cell #(
         .CLR_WINS   (CLR_WINS),
         .WR_OVER_SET(flag_wr_first(gi)),
         .RST_VAL    (1'b0)
      ) i_cell (
         .clk  (clk),
         .rst_n(rst_n),
         .set_i(set_v[gi]),
         .clr_i(clr_v[gi]),
         .wr_i (wr_v[gi]),
         .wd_i (wd_v[gi]),
         .q_o  (q[gi])
      );
   end

   always_comb begin
      status_o = '0;
      for (int i = 0; i < NFLAG; i++) status_o[flag_bit(i)] = q[i];
   end

   // R3: the active flag rises only after a permitted entry
   a_r3_act_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_o[6]) |-> $past(entry_i && status_o[7]));
   // R3: only the exit store drops the active flag
   a_r3_act_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status_o[6]) |-> $past(exit_store_i));
   // R5: step flag rises only under an enabled, active firmware step
   a_r5_step_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_o[3]) |-> $past(cmd_step_i && status_o[7] && status_o[6]));
   // R7: a locked unsecure bit ignores status writes
   a_r7_uns_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr_i && secured_i && !ssc_mode_i && !sec_enter_i && !verify_done_i)
      |=> (status_o[1] == $past(status_o[1])));
endmodule

// File: rtl/dbg_ccr_hold.sv
module dbg_ccr_hold #(
   parameter int              W       = 8,
   parameter logic [W-1:0]    SSC_RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ssc_mode_i,
   input  logic         cap_i,
   input  logic [W-1:0] cap_data_i,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] ccr_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)     ccr_o <= ssc_mode_i ? SSC_RST : '0;
      else if (cap_i) ccr_o <= cap_data_i;
      else if (wr_i)  ccr_o <= wdata_i;
   end

   // R9: a capture takes the user flags, even against a write
   a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
      cap_i |=> (ccr_o == $past(cap_data_i)));
   // R9: quiet cycles hold the value
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap_i && !wr_i) |=> $stable(ccr_o));
endmodule

// File: rtl/dbg_stat_ctrl.sv
module dbg_stat_ctrl
   import dbg_stat_pkg::*;
#(
   parameter int                 CCR_W       = 8,
   parameter logic [CCR_W-1:0]   CCR_SSC_RST = 8'hA0,
   parameter bit                 AUTO_EN     = 1'b1,
   parameter bit                 CLR_WINS    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ssc_mode_i,
   input  logic             secured_i,
   input  logic             stat_wr_i,
   input  logic [7:0]       stat_wdata_i,
   input  logic             entry_i,
   input  logic             exit_store_i,
   input  logic             cmd_rd_i,
   input  logic             cmd_wr_i,
   input  logic             cmd_fw_i,
   input  logic             cmd_step_i,
   input  logic             cmd_go_i,
   input  logic             cmd_gountil_i,
   input  logic             rd_done_i,
   input  logic             wr_done_i,
   input  logic             sec_enter_i,
   input  logic             verify_done_i,
   input  logic             verify_pass_i,
   input  logic [CCR_W-1:0] ccr_user_i,
   input  logic             ccr_wr_i,
   input  logic [CCR_W-1:0] ccr_wdata_i,
   output logic [7:0]       status_o,
   output logic [CCR_W-1:0] ccr_hold_o,
   output logic             entry_grant_o,
   output logic             fw_grant_o
);
   generate
      if (CCR_W < 4) begin : g_bad_w
         $error("CCR_W must be at least 4");
      end
      if (ST_W != 8) begin : g_bad_st
         $error("status byte must be 8 bits");
      end
   endgenerate

   logic auto_en;

   dbg_auto_en #(.ENABLE(AUTO_EN)) i_auto (
      .clk          (clk),
      .rst_n        (rst_n),
      .ssc_mode_i   (ssc_mode_i),
      .secured_i    (secured_i),
      .verify_done_i(verify_done_i),
      .en_set_o     (auto_en)
   );

   dbg_flag_bank #(.CLR_WINS(CLR_WINS)) i_flags (
      .clk          (clk),
      .rst_n        (rst_n),
      .ssc_mode_i   (ssc_mode_i),
      .secured_i    (secured_i),
      .stat_wr_i    (stat_wr_i),
      .stat_wdata_i (stat_wdata_i),
      .auto_en_i    (auto_en),
      .entry_i      (entry_i),
      .exit_store_i (exit_store_i),
      .cmd_rd_i     (cmd_rd_i),
      .cmd_wr_i     (cmd_wr_i),
      .cmd_fw_i     (cmd_fw_i),
      .cmd_step_i   (cmd_step_i),
      .cmd_go_i     (cmd_go_i),
      .cmd_gountil_i(cmd_gountil_i),
      .rd_done_i    (rd_done_i),
      .wr_done_i    (wr_done_i),
      .sec_enter_i  (sec_enter_i),
      .verify_done_i(verify_done_i),
      .verify_pass_i(verify_pass_i),
      .status_o     (status_o),
      .entry_grant_o(entry_grant_o),
      .fw_grant_o   (fw_grant_o)
   );

   dbg_ccr_hold #(.W(CCR_W), .SSC_RST(CCR_SSC_RST)) i_ccr (
      .clk       (clk),
      .rst_n     (rst_n),
      .ssc_mode_i(ssc_mode_i),
      .cap_i     (entry_grant_o),
      .cap_data_i(ccr_user_i),
      .wr_i      (ccr_wr_i),
      .wdata_i   (ccr_wdata_i),
      .ccr_o     (ccr_hold_o)
   );

   // R2: no entry grant while the enable flag is clear
   a_r2_entry_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !status_o[7] |-> !entry_grant_o);
   // R12: firmware grant requires enable and active
   a_r12_fw_gate: assert property (@(posedge clk) disable iff (!rst_n)
      fw_grant_o |-> (status_o[7] && status_o[6]));
endmodule

// File: tb/test_dbg_stat_ctrl.sv
module test_dbg_stat_ctrl;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n, ssc, secd, stwr, entry, exits, crd, cwr, cfw, cstep, cgo, cgou;
   logic rdd, wrd, secen, vdone, vpass, ccrwr;
   logic [7:0] stwd, ccru, ccrwd;
   logic [7:0] status, ccr;
   logic egrant, fgrant;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // bench reference state
   logic m_en, m_act, m_sdv, m_stp, m_uns, m_pend;
   logic [7:0] m_ccr;

   always #(CLK_PERIOD/2) clk = ~clk;

   dbg_stat_ctrl i_dbg_stat_ctrl (
      .clk(clk), .rst_n(rst_n), .ssc_mode_i(ssc), .secured_i(secd),
      .stat_wr_i(stwr), .stat_wdata_i(stwd), .entry_i(entry),
      .exit_store_i(exits), .cmd_rd_i(crd), .cmd_wr_i(cwr), .cmd_fw_i(cfw),
      .cmd_step_i(cstep), .cmd_go_i(cgo), .cmd_gountil_i(cgou),
      .rd_done_i(rdd), .wr_done_i(wrd), .sec_enter_i(secen),
      .verify_done_i(vdone), .verify_pass_i(vpass), .ccr_user_i(ccru),
      .ccr_wr_i(ccrwr), .ccr_wdata_i(ccrwd), .status_o(status),
      .ccr_hold_o(ccr), .entry_grant_o(egrant), .fw_grant_o(fgrant)
   );

   function automatic logic [7:0] exp_status();
      return {m_en, m_act, 1'b0, m_sdv, m_stp, 1'b0, m_uns, 1'b0};
   endfunction

   function automatic logic exp_fw();
      return (cstep | cgo | cgou | ((crd | cwr) & cfw)) & m_en & m_act;
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic clear_in();
      stwr = 0; stwd = 0; entry = 0; exits = 0; crd = 0; cwr = 0; cfw = 0;
      cstep = 0; cgo = 0; cgou = 0; rdd = 0; wrd = 0; secen = 0;
      vdone = 0; vpass = 0; ccrwr = 0; ccru = 0; ccrwd = 0;
   endtask

   // reference update from the requirements
   task automatic model_step();
      logic fw_ok, eg, anyc, aset;
      if (!rst_n) begin
         {m_en, m_act, m_sdv, m_stp, m_uns} = '0;       // R1
         m_ccr  = ssc ? 8'hA0 : 8'h00;                  // R10
         m_pend = 1'b1;
         return;
      end
      fw_ok = m_en & m_act;
      eg    = entry & m_en;
      anyc  = crd | cwr | cstep | cgo | cgou;
      aset  = m_pend & ssc & (!secd | vdone);           // R11
      m_pend = m_pend & ssc & secd & !vdone;
      if (eg) m_ccr = ccru; else if (ccrwr) m_ccr = ccrwd;
      if (stwr & (!secd | ssc)) m_uns = stwd[1];
      if (vdone & vpass) m_uns = 1'b1;
      if (secen) m_uns = 1'b0;
      if (rdd | wrd) m_sdv = 1'b1;
      if (anyc | exits) m_sdv = 1'b0;
      if (cstep & fw_ok) m_stp = 1'b1;
      if ((cgo | cgou) & fw_ok) m_stp = 1'b0;
      if (eg) m_act = 1'b1;
      if (exits) m_act = 1'b0;
      if (aset) m_en = 1'b1;
      if (stwr) m_en = stwd[7];
   endtask

   // inputs are set at a falling edge; run one clock and compare
   task automatic cyc();
      #1;
      if (rst_n) begin
         chk("R2 entry grant", {7'd0, egrant}, {7'd0, entry & m_en});
         chk("R12 fw grant", {7'd0, fgrant}, {7'd0, exp_fw()});
      end
      model_step();
      @(posedge clk);
      #1;
      chk("R1-model status", status, exp_status());
      chk("R9 ccr model", ccr, m_ccr);
      @(negedge clk);
      clear_in();
   endtask

   task automatic do_reset(input logic s, input logic sc);
      ssc = s; secd = sc; rst_n = 0;
      cyc(); cyc();
      rst_n = 1;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      clear_in();
      rst_n = 0; ssc = 1; secd = 0;
      m_pend = 1; m_ccr = 0; {m_en, m_act, m_sdv, m_stp, m_uns} = '0;
      @(negedge clk);
      // special single-chip, unsecured
      do_reset(1'b1, 1'b0);
      chk("R1 reset status", status, 8'h00);
      chk("R10 ssc ccr reset", ccr, 8'hA0);
      cyc();
      chk("R11 auto enable unsecured", status, 8'h80);
      stwr = 1; stwd = 8'h7F; cyc();
      chk("R8 reserved bits ignored", status, 8'h02);
      entry = 1; ccru = 8'h11; cyc();
      chk("R2 entry refused when disabled", status, 8'h02);
      crd = 1; cyc(); rdd = 1; cyc();
      chk("R2 hardware read sets data flag", status, 8'h12);
      stwr = 1; stwd = 8'h80; cyc();
      chk("R7 unsecure write allowed", status, 8'h90);
      entry = 1; ccru = 8'h5C; ccrwr = 1; ccrwd = 8'h33; cyc();
      chk("R3 active after entry", status, 8'hD0);
      chk("R9 capture beats write", ccr, 8'h5C);
      cstep = 1; cyc();
      chk("R5 step set, R4 cleared by command", status, 8'hC8);
      cwr = 1; cfw = 1; cyc(); wrd = 1; cyc();
      chk("R4 write data phase", status, 8'hD8);
      crd = 1; rdd = 1; cyc();
      chk("R4 clear wins", status, 8'hC8);
      cgo = 1; cstep = 1; cyc();
      chk("R5 go clears step", status, 8'hC0);
      ccrwr = 1; ccrwd = 8'h3C; cyc();
      chk("R9 direct write", ccr, 8'h3C);
      rdd = 1; cyc(); exits = 1; cyc();
      chk("R3 exit store", status, 8'h80);
      // normal mode, secured
      do_reset(1'b0, 1'b1);
      chk("R10 normal ccr reset", ccr, 8'h00);
      cyc(); cyc();
      chk("R11 no auto enable outside ssc", status, 8'h00);
      stwr = 1; stwd = 8'h82; cyc();
      chk("R7 locked unsecure write", status, 8'h80);
      vdone = 1; vpass = 1; cyc();
      chk("R6 verify pass", status, 8'h82);
      vdone = 1; vpass = 1; secen = 1; cyc();
      chk("R6 secure entry wins", status, 8'h80);
      vdone = 1; vpass = 0; cyc();
      chk("R6 verify fail", status, 8'h80);
      // ssc, secured
      do_reset(1'b1, 1'b1);
      cyc(); cyc(); cyc();
      chk("R11 waits for verify", status, 8'h00);
      vdone = 1; vpass = 0; cyc();
      chk("R11 enable after verify", status, 8'h80);
      stwr = 1; stwd = 8'h02; cyc(); cyc();
      chk("R11 one shot", status, 8'h02);
      // constrained random
      void'($urandom(32'h5EED1));
      for (int seg = 0; seg < 8; seg++) begin
         do_reset(1'($urandom), 1'($urandom));
         for (int k = 0; k < 250; k++) begin
            stwr  = ($urandom % 16) == 0; stwd = 8'($urandom);
            entry = ($urandom % 8) == 0; exits = ($urandom % 12) == 0;
            crd = ($urandom % 6) == 0; cwr = ($urandom % 6) == 0;
            cfw = 1'($urandom); cstep = ($urandom % 8) == 0;
            cgo = ($urandom % 10) == 0; cgou = ($urandom % 12) == 0;
            rdd = ($urandom % 5) == 0; wrd = ($urandom % 5) == 0;
            secen = ($urandom % 20) == 0; vdone = ($urandom % 10) == 0;
            vpass = 1'($urandom); ccru = 8'($urandom);
            ccrwr = ($urandom % 6) == 0; ccrwd = 8'($urandom);
            if (($urandom % 4) == 0) begin
               stwr = 1; stwd[7] = 1;
            end
            cyc();
         end
      end
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule